// File: doc/BRIEF.md
# External memory bus strobe sequencer

This block times the external bus of an 8-bit microcontroller core. It runs on the oscillator clock and splits it into machine cycles of twelve oscillator periods: six states of two phases each, which is the same as a divide-by-two internal clock. In every machine cycle it produces the address latch pulse, the program read strobe and the data read and write strobes. It also chooses what the low and high address/data byte lanes carry.

At each machine-cycle boundary the block samples the program counter, the external-code pin and any data request. It decides whether the cycle is an internal fetch, an external fetch or an external data access. A data access takes the place of a whole fetch cycle. In that cycle the second latch pulse and both program read pulses are dropped, and a read or write strobe is driven in their place.

A small write port holds two control registers: a latch-pulse disable bit and the high-byte port latch. A qualified reset output is asserted only after the raw reset pin has been held high for two full machine cycles.

Top module: `bsq_top`

## Requirements
- R1: A machine cycle is STATES*PHASES = 12 clock periods. The latch pulse `alat_o` is high in state 0 (ticks 0-1) and in state 3 (ticks 6-7). This gives two pulses in every non-data cycle while the disable bit is clear.
- R2: A cycle fetches externally when `code_ext_ni` is 0, or when `pc_i` >= INT_SIZE (4096). Otherwise it fetches internally. The choice is sampled at the machine-cycle boundary.
- R3: An external-fetch cycle drives `pfetch_no` low twice, in ticks 2-5 and 8-11. An internal-fetch cycle never drives it low.
- R4: A data request (`dreq_i`=1 at the boundary) makes a data cycle. A data cycle has one latch pulse (ticks 0-1) and no `pfetch_no` pulse. It holds `rd_no` low (`dwr_i`=0) or `wr_no` low (`dwr_i`=1) for ticks 2-9, which is 8 ticks.
- R5: A write to SFR address 8Eh sets the latch-disable bit from data bit 0. While the bit is set, internal-fetch non-data cycles emit no latch pulse. External-fetch cycles still emit two, and data cycles still emit one. A write to any other address leaves the bit unchanged.
- R6: `hi_byte_o` carries `pc_i[15:8]` in an external-fetch cycle and `daddr_i[15:8]` in a wide data cycle (`dwide_i`=1). In every other cycle, including a narrow data cycle, it carries the high-byte latch. The latch is written at SFR address A0h.
- R7: `lo_mode_o` encodes the low lane as 0 = port, 1 = address, 2 = data out, 3 = data in. It is 1 in the latch-pulse states of external-fetch and data cycles. In the other states it is 3 for external fetch and data reads, 2 for data writes, and 0 for internal-fetch cycles. `lo_addr_o` gives the cycle's low address byte.
- R8: `rst_qual_o` rises after `rst_pin_i` has been sampled high on 24 consecutive clock edges (two machine cycles). It falls on the first edge that samples the pin low.
- R9: While `rst_qual_o` is high, the latch-disable bit clears and the high-byte latch loads FFh.
- R10: While `rst_ni` is low, `alat_o`=0, `pfetch_no`=`rd_no`=`wr_no`=1, `lo_mode_o`=0, `hi_byte_o`=FFh and `rst_qual_o`=0. The first edge after release starts a machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_pin_i | input | 1 | Raw active-high reset pin |
| code_ext_ni | input | 1 | Low forces all fetches external |
| pc_i | input | 16 | Program counter |
| dreq_i | input | 1 | External data access request |
| dwr_i | input | 1 | Data access is a write |
| dwide_i | input | 1 | Data access uses a 16-bit pointer |
| daddr_i | input | 16 | Data address |
| sfr_we_i | input | 1 | SFR write enable |
| sfr_addr_i | input | 8 | SFR write address |
| sfr_wdata_i | input | 8 | SFR write data |
| alat_o | output | 1 | Address latch pulse |
| pfetch_no | output | 1 | Program read strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| lo_mode_o | output | 2 | Low lane mode |
| lo_addr_o | output | 8 | Low address byte |
| hi_byte_o | output | 8 | High lane byte |
| hi_addr_o | output | 1 | High lane carries an address |
| rst_qual_o | output | 1 | Qualified reset |

## Verification
A qualified reset can arrive in the same machine-cycle boundary as a pending SFR write to the latch-disable bit. The reset clear and the disable setting then compete for the same register. The bench raises the reset pin exactly at a boundary, so the qualified reset rises on the last tick of the following cycle and clears the bit on the next boundary edge. This is judged by counting latch pulses in the cycles on either side.

Data cycles are also mixed randomly with external fetches and disable-bit writes. Every boundary checks that the dropped pulses and the substituted data strobe fall in the same cycle.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {
    LO_PORT = 2'd0,
    LO_ADDR = 2'd1,
    LO_DOUT = 2'd2,
    LO_DIN  = 2'd3
  } lo_mode_e;

  typedef struct packed {
    logic data;
    logic wr;
    logic wide;
    logic ext;
  } cyc_attr_t;
endpackage

// File: rtl/bsq_timing.sv
module bsq_timing #(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int SW = $clog2(STATES),
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [SW-1:0] state_o,
  output logic          last_o,
  output logic          mid_o
);
  localparam logic [PW-1:0] PH_LAST = PW'(PHASES - 1);
  localparam logic [SW-1:0] ST_LAST = SW'(STATES - 1);
  localparam logic [SW-1:0] ST_MID  = SW'(STATES / 2 - 1);

  logic [PW-1:0] ph_q;
  logic [SW-1:0] st_q;

  // reset parks on the last tick so the first edge opens a cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_LAST;
      st_q <= ST_LAST;
    end else if (ph_q == PH_LAST) begin
      ph_q <= '0;
      st_q <= (st_q == ST_LAST) ? '0 : st_q + 1'b1;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign state_o = st_q;
  assign last_o  = (ph_q == PH_LAST) && (st_q == ST_LAST);
  assign mid_o   = (ph_q == PH_LAST) && (st_q == ST_MID);
endmodule

// File: rtl/bsq_rst_qual.sv
module bsq_rst_qual #(
  parameter int LIMIT = 24,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rst_qual_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!pin_i)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign rst_qual_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/bsq_sfr.sv
module bsq_sfr #(
  parameter logic [7:0] LATCH_CTRL_ADDR = 8'h8E,
  parameter logic [7:0] HI_LATCH_ADDR   = 8'hA0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       alat_dis_o,
  output logic [7:0] hi_latch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alat_dis_o <= 1'b0;
      hi_latch_o <= 8'hFF;
    end else if (clr_i) begin
      alat_dis_o <= 1'b0;
      hi_latch_o <= 8'hFF;
    end else if (we_i) begin
      if (addr_i == LATCH_CTRL_ADDR) alat_dis_o <= wdata_i[0];
      if (addr_i == HI_LATCH_ADDR)   hi_latch_o <= wdata_i;
    end
  end
endmodule

// File: rtl/bsq_cycle.sv
module bsq_cycle
  import bsq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int INT_SIZE = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  logic              mid_i,
  input  logic              code_ext_ni,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              dreq_i,
  input  logic              dwr_i,
  input  logic              dwide_i,
  input  logic [ADDR_W-1:0] daddr_i,
  output cyc_attr_t         attr_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W:0] INT_LIM = (ADDR_W+1)'(INT_SIZE);

  logic              ext_d;
  logic [ADDR_W-1:0] daddr_eff;

  assign ext_d     = !code_ext_ni || ({1'b0, pc_i} >= INT_LIM);
  assign daddr_eff = dwide_i ? daddr_i : {{(ADDR_W-8){1'b0}}, daddr_i[7:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_o <= '0;
      addr_o <= '0;
    end else if (last_i) begin
      attr_o <= '{data: dreq_i, wr: dwr_i, wide: dwide_i, ext: ext_d};
      addr_o <= dreq_i ? daddr_eff : pc_i;
    end else if (mid_i && attr_o.ext && !attr_o.data) begin
      addr_o <= pc_i;  // second fetch of the cycle
    end
  end
endmodule

// File: rtl/bsq_top.sv
module bsq_top
  import bsq_pkg::*;
#(
  parameter int         ADDR_W          = 16,
  parameter int         STATES          = 6,
  parameter int         PHASES          = 2,
  parameter int         INT_SIZE        = 4096,
  parameter int         RST_MCYC        = 2,
  parameter logic [7:0] LATCH_CTRL_ADDR = 8'h8E,
  parameter logic [7:0] HI_LATCH_ADDR   = 8'hA0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_i,
  input  logic              code_ext_ni,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              dreq_i,
  input  logic              dwr_i,
  input  logic              dwide_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic              sfr_we_i,
  input  logic [7:0]        sfr_addr_i,
  input  logic [7:0]        sfr_wdata_i,
  output logic              alat_o,
  output logic              pfetch_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [1:0]        lo_mode_o,
  output logic [7:0]        lo_addr_o,
  output logic [ADDR_W-9:0] hi_byte_o,
  output logic              hi_addr_o,
  output logic              rst_qual_o
);
  localparam int CYC = STATES * PHASES;
  localparam int SW  = $clog2(STATES);
  localparam logic [SW-1:0] ST_HALF = SW'(STATES / 2);
  localparam logic [SW-1:0] ST_LAST = SW'(STATES - 1);

  logic [SW-1:0]     state;
  logic              last, mid, alat_dis;
  logic [7:0]        hi_latch;
  cyc_attr_t         attr;
  logic [ADDR_W-1:0] addr;
  lo_mode_e          lo_mode;

  bsq_timing #(.STATES(STATES), .PHASES(PHASES)) u_timing (
    .clk_i, .rst_ni, .state_o(state), .last_o(last), .mid_o(mid)
  );

  bsq_rst_qual #(.LIMIT(RST_MCYC * CYC)) u_rst_qual (
    .clk_i, .rst_ni, .pin_i(rst_pin_i), .rst_qual_o
  );

  bsq_sfr #(.LATCH_CTRL_ADDR(LATCH_CTRL_ADDR), .HI_LATCH_ADDR(HI_LATCH_ADDR)) u_sfr (
    .clk_i, .rst_ni, .clr_i(rst_qual_o), .we_i(sfr_we_i), .addr_i(sfr_addr_i),
    .wdata_i(sfr_wdata_i), .alat_dis_o(alat_dis), .hi_latch_o(hi_latch)
  );

  bsq_cycle #(.ADDR_W(ADDR_W), .INT_SIZE(INT_SIZE)) u_cycle (
    .clk_i, .rst_ni, .last_i(last), .mid_i(mid), .code_ext_ni, .pc_i,
    .dreq_i, .dwr_i, .dwide_i, .daddr_i, .attr_o(attr), .addr_o(addr)
  );

  logic alat_win, alat_en, fetch_win, strobe, addr_state;

  assign addr_state = (state == '0) || (state == ST_HALF);
  // a data cycle drops the second latch pulse
  assign alat_win   = (state == '0) || ((state == ST_HALF) && !attr.data);
  // disable bit is overridden by external fetch and data cycles
  assign alat_en    = attr.ext || attr.data || !alat_dis;
  assign alat_o     = alat_win && alat_en;

  assign fetch_win  = !addr_state;
  assign pfetch_no  = !(attr.ext && !attr.data && fetch_win);

  assign strobe     = attr.data && (state != '0) && (state != ST_LAST);
  assign rd_no      = !(strobe && !attr.wr);
  assign wr_no      = !(strobe && attr.wr);

  always_comb begin
    if (attr.data)     lo_mode = (state == '0) ? LO_ADDR : (attr.wr ? LO_DOUT : LO_DIN);
    else if (attr.ext) lo_mode = addr_state ? LO_ADDR : LO_DIN;
    else               lo_mode = LO_PORT;
  end

  assign lo_mode_o = lo_mode;
  assign lo_addr_o = addr[7:0];
  assign hi_addr_o = (attr.ext && !attr.data) || (attr.data && attr.wide);
  assign hi_byte_o = hi_addr_o ? addr[ADDR_W-1:8] : hi_latch;
endmodule

// File: rtl/bsq_top_chk.sv
module bsq_top_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rst_pin_i,
  input logic       alat_o,
  input logic       pfetch_no,
  input logic       rd_no,
  input logic       wr_no,
  input logic [1:0] lo_mode_o,
  input logic       rst_qual_o
);
  // R4
  fetch_data_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!pfetch_no && (!rd_no || !wr_no)));
  // R4
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_no || wr_no);
  // R1
  alat_fetch_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alat_o && !pfetch_no));
  // R1
  alat_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alat_o) |=> alat_o);
  // R3
  fetch_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pfetch_no) |=> !pfetch_no);
  // R8
  rst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_qual_o) |-> $past(rst_pin_i));
  // R7
  lo_din_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pfetch_no || !rd_no) |-> lo_mode_o == 2'd3);
  // R7
  lo_dout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> lo_mode_o == 2'd2);
endmodule

bind bsq_top bsq_top_chk u_chk (.*);

// File: tb/tb_bsq_top.sv
module tb_bsq_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rst_pin = 1'b0, code_ext_n = 1'b1, dreq = 1'b0, dwr = 1'b0, dwide = 1'b0;
  logic [15:0] pc = '0, daddr = '0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = '0, sfr_wdata = '0;
  logic        alat, pfetch_n, rd_n, wr_n, hi_addr, rst_qual;
  logic [1:0]  lo_mode;
  logic [7:0]  lo_addr, hi_byte;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit m_dis = 0;
  logic [7:0] m_hi = 8'hFF;
  int pin_cnt = 0;
  bit last_q = 0;
  int last_alat, last_fetch, last_rq_max;
  logic [7:0] last_hi;

  always #10 clk = ~clk;

  bsq_top dut (
    .clk_i(clk), .rst_ni, .rst_pin_i(rst_pin), .code_ext_ni(code_ext_n), .pc_i(pc),
    .dreq_i(dreq), .dwr_i(dwr), .dwide_i(dwide), .daddr_i(daddr),
    .sfr_we_i(sfr_we), .sfr_addr_i(sfr_addr), .sfr_wdata_i(sfr_wdata),
    .alat_o(alat), .pfetch_no(pfetch_n), .rd_no(rd_n), .wr_no(wr_n),
    .lo_mode_o(lo_mode), .lo_addr_o(lo_addr), .hi_byte_o(hi_byte),
    .hi_addr_o(hi_addr), .rst_qual_o(rst_qual)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_alat(bit d, bit e, bit dis);
    if (d) return 1;
    return (e || !dis) ? 2 : 0;
  endfunction

  function automatic int exp_mode(bit d, bit w, bit e, int j);
    if (d) return (j < 2) ? 1 : (w ? 2 : 3);
    if (e) return (j < 2 || (j >= 6 && j < 8)) ? 1 : 3;
    return 0;
  endfunction

  // applies inputs at a boundary, then runs and checks one machine cycle
  task automatic do_cycle(input bit ea_n, input logic [15:0] p, input bit d, input bit w,
                          input bit wd, input logic [15:0] da, input bit we,
                          input logic [7:0] sa, input logic [7:0] sd, input bit pin);
    bit e;
    int na = 0, nf = 0, nr = 0, nw = 0, rq_bad = 0, rq_max = 0;
    bit pa = 0, pf = 1;
    logic [7:0] exp_hi;
    if (last_q) begin m_dis = 0; m_hi = 8'hFF; end
    else if (we) begin
      if (sa == 8'h8E) m_dis = sd[0];
      if (sa == 8'hA0) m_hi = sd;
    end
    code_ext_n = ea_n; pc = p; dreq = d; dwr = w; dwide = wd; daddr = da;
    sfr_we = we; sfr_addr = sa; sfr_wdata = sd; rst_pin = pin;
    e = !ea_n || (p >= 16'd4096);
    exp_hi = (d && wd) ? da[15:8] : ((e && !d) ? p[15:8] : m_hi);
    for (int j = 0; j < 12; j++) begin
      @(posedge clk);
      pin_cnt = rst_pin ? ((pin_cnt < 24) ? pin_cnt + 1 : 24) : 0;
      @(negedge clk);
      if (j == 0) sfr_we = 1'b0;
      if (alat && !pa) na++;
      if (!pfetch_n && pf) nf++;
      if (!rd_n) nr++;
      if (!wr_n) nw++;
      pa = alat; pf = pfetch_n;
      if (int'(rst_qual) != int'(pin_cnt >= 24)) rq_bad++;
      if (rst_qual) rq_max = 1;
      if (j == 0 || j == 4) chk(int'(lo_mode), exp_mode(d, w, e, j), "R7 lane mode");
      if (j == 0 && (d || e)) chk(int'(lo_addr), d ? int'(da[7:0]) : int'(p[7:0]), "R7 low address");
      if (j == 3) begin
        chk(int'(hi_byte), int'(exp_hi), "R6 high byte");
        last_hi = hi_byte;
      end
      if (j == 11) last_q = rst_qual;
    end
    if (d) chk(na, 1, "R4 latch pulses in data cycle");
    else if (m_dis) chk(na, exp_alat(d, e, m_dis), "R5 latch pulses with disable");
    else chk(na, 2, "R1 latch pulses");
    chk(nf, (e && !d) ? 2 : 0, "R3 fetch pulses");
    chk(nr, (d && !w) ? 8 : 0, "R4 read ticks");
    chk(nw, (d && w) ? 8 : 0, "R4 write ticks");
    chk(rq_bad, 0, "R8 qualified reset timing");
    last_alat = na; last_fetch = nf; last_rq_max = rq_max;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(int'(alat), 0, "R10 latch in reset");
    chk(int'(pfetch_n), 1, "R10 fetch strobe in reset");
    chk(int'(rd_n & wr_n), 1, "R10 data strobes in reset");
    chk(int'(lo_mode), 0, "R10 lane mode in reset");
    chk(int'(hi_byte), 8'hFF, "R10 high byte in reset");
    chk(int'(rst_qual), 0, "R10 qualified reset in reset");
    rst_ni = 1'b1;

    do_cycle(1, 16'h0100, 0, 0, 0, 0, 0, 0, 0, 0);
    do_cycle(1, 16'h0FFF, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(last_fetch, 0, "R2 top of internal space");
    do_cycle(1, 16'h1000, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(last_fetch, 2, "R2 first external address");
    do_cycle(0, 16'h0010, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(last_fetch, 2, "R2 external pin forces fetch");
    do_cycle(1, 16'h0200, 0, 0, 0, 0, 1, 8'h8E, 8'h01, 0);
    chk(last_alat, 0, "R5 disabled internal fetch");
    do_cycle(1, 16'h2345, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(last_alat, 2, "R5 external fetch overrides disable");
    do_cycle(1, 16'h0300, 1, 0, 0, 16'h1234, 0, 0, 0, 0);
    do_cycle(1, 16'h0300, 0, 0, 0, 0, 1, 8'h8F, 8'h00, 0);
    chk(last_alat, 0, "R5 other address ignored");
    do_cycle(1, 16'h0300, 1, 1, 0, 16'h9977, 1, 8'hA0, 8'h5A, 0);
    chk(int'(last_hi), 8'h5A, "R6 narrow pointer uses latch");
    do_cycle(0, 16'h0400, 1, 0, 1, 16'hBEEF, 0, 0, 0, 0);
    chk(int'(last_hi), 8'hBE, "R6 wide pointer high byte");

    for (int k = 0; k < 80; k++) begin
      bit ea_n = ($urandom % 4) != 0;
      logic [15:0] p = ($urandom % 2) ? 16'($urandom % 4096) : 16'(4096 + $urandom % 61440);
      bit we = ($urandom % 5) == 0;
      logic [7:0] sa = (($urandom % 3) == 0) ? 8'h8F : ((($urandom % 2) == 0) ? 8'h8E : 8'hA0);
      do_cycle(ea_n, p, ($urandom % 3) == 0, $urandom % 2, $urandom % 2,
               16'($urandom), we, sa, 8'($urandom), 0);
    end

    // R8 short pulse does not qualify
    do_cycle(1, 16'h0050, 0, 0, 0, 0, 1, 8'h8E, 8'h01, 1);
    do_cycle(1, 16'h0050, 0, 0, 0, 0, 1, 8'hA0, 8'h33, 0);
    chk(last_rq_max, 0, "R8 one cycle is too short");
    chk(last_alat, 0, "R8 short pulse keeps disable");
    // R9 full qualification clears both registers
    do_cycle(1, 16'h0050, 0, 0, 0, 0, 0, 0, 0, 1);
    do_cycle(1, 16'h0050, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(last_rq_max, 1, "R8 two cycles qualify");
    chk(last_alat, 0, "R9 disable held until boundary");
    do_cycle(1, 16'h0050, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(last_alat, 2, "R9 disable cleared");
    chk(int'(last_hi), 8'hFF, "R9 high latch reloaded");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule